// File: doc/BRIEF.md
# Prime Sieve Coprocessor

This block is a request/acknowledge coprocessor built around a persistent flag memory of one bit per integer from 0 to 1024. A request carries a mode code and a start index. In the build mode the block wipes every flag and then runs the sieve of Eratosthenes over the memory, setting the flag of every composite number up to 1024. In the query mode it walks upward from the start index and hands back the first index whose flag is still clear.

The flag memory is never cleared by reset or by a query, so one build request serves any number of later queries. A host issues a build once, then issues queries with increasing start indices to list the primes one at a time. The engine is a multi-cycle state machine. A registered memory with one write port and one read port sits under it, and the read data arrives one cycle after the address.

Top module: `prime_sieve_cop`

## Requirements
- R1: While `rst_n` is low at a clock edge the block returns to idle, `ack_o` reads 0 and `result_o` reads 0; the flag memory keeps its contents.
- R2: A request is accepted when `req_i` is high at a clock edge while the block is idle. Every accepted request raises `ack_o` for exactly one cycle. `result_o` holds its final value in that cycle and changes at no other time outside reset.
- R3: A mode code other than 0 or 1 raises `ack_o` in the first cycle after acceptance. `result_o` and the flag memory stay unchanged.
- R4: Mode code 0 (build) first clears all 1025 flags. Then, for each seed m from 2 to 32 whose flag reads 0, it sets the flags of 2m, 3m, ... up to 1024. `result_o` is left unchanged.
- R5: Mode code 1 (query) returns on `result_o` the smallest index i with start ≤ i ≤ 1024 whose flag is 0. After a build, these are exactly 0, 1 and the primes up to 1024.
- R6: A query that finds no clear flag returns 0. This includes a start index above 1024, which completes in the first cycle after acceptance.
- R7: Flags survive both later requests and a reset, so queries issued after a reset return the same answers as before it.
- R8: A query with start ≤ 1024 that stops at index f (the found index, or 1024 when nothing is found) raises `ack_o` in cycle 2·(f − start) + 3 after acceptance.
- R9: Indices 0 and 1 are never set by a build, so a query from 0 returns 0 and a query from 1 returns 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Request strobe, sampled while idle |
| stage_i | input | 32 | Mode code: 0 build, 1 query, others no operation |
| start_i | input | 32 | First index examined by a query (unsigned) |
| result_o | output | 32 | Query answer, valid while `ack_o` is high |
| ack_o | output | 1 | One-cycle completion pulse |

## Verification
The bench queries from every start index from 0 to 1030 after a build. It compares both the answer and the acknowledge cycle against a sieve it computes by trial division. This covers an off-by-one read latency: a design that tested the flag in the same cycle as the address would report stale flags and miss primes. The same sweep covers the upper edge. A design that stopped short of 1024, or did not treat out-of-range starts as empty, would return a wrong index or hang. Two further corners are checked. A no-op mode code must not clobber the held answer or the flags. A reset must leave the flags intact, and a design that cleared or wrote memory on reset would fail every later query.

// File: rtl/sieve_pkg.sv
// Package: shared state encoding for the prime sieve coprocessor.
// Assumes nothing beyond IEEE 1800-2017 enumerations.
package sieve_pkg;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_CLEAR       = 3'd1,
        ST_PROBE_ISSUE = 3'd2,
        ST_PROBE_TEST  = 3'd3,
        ST_MARK        = 3'd4,
        ST_SCAN_ISSUE  = 3'd5,
        ST_SCAN_TEST   = 3'd6,
        ST_DONE        = 3'd7
    } sieve_state_t;

endpackage

// File: rtl/sieve_flag_ram.sv
// Module: sieve_flag_ram
// One-bit-wide memory with one write port and one registered read port.
// Assumes: read data appears one cycle after rd_en; a write and a read of the
// same address in one cycle return the old value. No reset: contents persist.
module sieve_flag_ram #(
    parameter int DEPTH  = 1025,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              wr_bit_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              rd_bit_o
);

    logic flags [DEPTH];

    // Write port: store one flag when enabled.
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            flags[wr_addr_i] <= wr_bit_i;
        end
    end

    // Read port: register the addressed flag for use next cycle.
    always_ff @(posedge clk) begin
        if (rd_en_i) begin
            rd_bit_o <= flags[rd_addr_i];
        end
    end

endmodule

// File: rtl/sieve_ctrl.sv
// Module: sieve_ctrl
// Request/acknowledge sequencer for the sieve: clear sweep, seed probing,
// multiple marking and the upward scan of a query. Assumes the flag memory
// has one cycle of read latency and that 2*SEED_LAST <= MAX_IDX.
module sieve_ctrl
    import sieve_pkg::*;
#(
    parameter int MAX_IDX   = 1024,
    parameter int SEED_LAST = 32,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = $clog2(MAX_IDX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [DATA_W-1:0] stage_i,
    input  logic [DATA_W-1:0] start_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              wr_bit_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_bit_i
);

    localparam int IDX_W = ADDR_W + 1;
    localparam logic [IDX_W-1:0] MAX_I   = IDX_W'(MAX_IDX);
    localparam logic [IDX_W-1:0] SEED_F  = IDX_W'(2);
    localparam logic [IDX_W-1:0] SEED_L  = IDX_W'(SEED_LAST);

    sieve_state_t      state_q, state_n;
    logic [IDX_W-1:0]  idx_q, idx_n;
    logic [IDX_W-1:0]  seed_q, seed_n;
    logic [DATA_W-1:0] res_q, res_n;
    logic              seeds_done;

    assign seeds_done = (seed_q == SEED_L);

    // Next-state, counters and memory strobes for the current state.
    always_comb begin
        state_n = state_q;
        idx_n   = idx_q;
        seed_n  = seed_q;
        res_n   = res_q;
        wr_en_o = 1'b0;
        wr_bit_o = 1'b0;
        rd_en_o = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    if (stage_i == DATA_W'(0)) begin
                        idx_n   = '0;
                        state_n = ST_CLEAR;
                    end else if (stage_i == DATA_W'(1)) begin
                        if (start_i > DATA_W'(MAX_IDX)) begin
                            res_n   = '0;
                            state_n = ST_DONE;
                        end else begin
                            idx_n   = IDX_W'(start_i);
                            state_n = ST_SCAN_ISSUE;
                        end
                    end else begin
                        state_n = ST_DONE;
                    end
                end
            end
            ST_CLEAR: begin
                wr_en_o = 1'b1;
                if (idx_q == MAX_I) begin
                    seed_n  = SEED_F;
                    state_n = ST_PROBE_ISSUE;
                end else begin
                    idx_n = idx_q + 1'b1;
                end
            end
            ST_PROBE_ISSUE: begin
                rd_en_o = 1'b1;
                state_n = ST_PROBE_TEST;
            end
            ST_PROBE_TEST: begin
                if (!rd_bit_i) begin
                    idx_n   = seed_q << 1;
                    state_n = ST_MARK;
                end else if (seeds_done) begin
                    state_n = ST_DONE;
                end else begin
                    seed_n  = seed_q + 1'b1;
                    state_n = ST_PROBE_ISSUE;
                end
            end
            ST_MARK: begin
                wr_en_o  = 1'b1;
                wr_bit_o = 1'b1;
                if ((idx_q + seed_q) <= MAX_I) begin
                    idx_n = idx_q + seed_q;
                end else if (seeds_done) begin
                    state_n = ST_DONE;
                end else begin
                    seed_n  = seed_q + 1'b1;
                    state_n = ST_PROBE_ISSUE;
                end
            end
            ST_SCAN_ISSUE: begin
                rd_en_o = 1'b1;
                state_n = ST_SCAN_TEST;
            end
            ST_SCAN_TEST: begin
                if (!rd_bit_i) begin
                    res_n   = DATA_W'(idx_q);
                    state_n = ST_DONE;
                end else if (idx_q == MAX_I) begin
                    res_n   = '0;
                    state_n = ST_DONE;
                end else begin
                    idx_n   = idx_q + 1'b1;
                    state_n = ST_SCAN_ISSUE;
                end
            end
            ST_DONE: begin
                state_n = ST_IDLE;
            end
            default: begin
                state_n = ST_IDLE;
            end
        endcase
    end

    // Control registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            seed_q  <= SEED_F;
            res_q   <= '0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
            seed_q  <= seed_n;
            res_q   <= res_n;
        end
    end

    assign wr_addr_o = idx_q[ADDR_W-1:0];
    assign rd_addr_o = (state_q == ST_PROBE_ISSUE) ? seed_q[ADDR_W-1:0]
                                                   : idx_q[ADDR_W-1:0];
    assign ack_o     = (state_q == ST_DONE);
    assign result_o  = res_q;

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o); // R2

    AST_RESULT_ONLY_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> ack_o); // R2

    AST_NOOP_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_i && stage_i > DATA_W'(1)) |=> ack_o); // R3

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (idx_q <= MAX_I)); // R4

    AST_SEEDS_UNMARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_bit_o) |-> (idx_q >= IDX_W'(4))); // R9

    AST_SCAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN_ISSUE || state_q == ST_SCAN_TEST) |-> (idx_q <= MAX_I)); // R6

endmodule

// File: rtl/prime_sieve_cop.sv
// Module: prime_sieve_cop (top)
// Prime sieve coprocessor: a sequencer and a persistent one-bit flag memory.
// Assumes requests are issued only while ack_o is low and the block is idle;
// a request raised during a busy operation is ignored until idle.
module prime_sieve_cop #(
    parameter int MAX_IDX   = 1024,
    parameter int SEED_LAST = 32,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [DATA_W-1:0] stage_i,
    input  logic [DATA_W-1:0] start_i,
    output logic [DATA_W-1:0] result_o,
    output logic              ack_o
);

    localparam int DEPTH  = MAX_IDX + 1;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic              wr_bit;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_bit;

    sieve_ctrl #(
        .MAX_IDX   (MAX_IDX),
        .SEED_LAST (SEED_LAST),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .stage_i   (stage_i),
        .start_i   (start_i),
        .ack_o     (ack_o),
        .result_o  (result_o),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_bit_o  (wr_bit),
        .rd_en_o   (rd_en),
        .rd_addr_o (rd_addr),
        .rd_bit_i  (rd_bit)
    );

    sieve_flag_ram #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_flags (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_bit_i  (wr_bit),
        .rd_en_i   (rd_en),
        .rd_addr_i (rd_addr),
        .rd_bit_o  (rd_bit)
    );

endmodule

// File: tb/prime_sieve_cop_test.sv
// Bench for prime_sieve_cop: exhaustive query sweep against a trial-division
// model, plus no-op modes, reset persistence and result hold.
module prime_sieve_cop_test;

    localparam int MAX_IDX  = 1024;
    localparam int SEEDS    = 32;
    localparam int WATCHDOG = 180000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [31:0] stage_i = '0;
    logic [31:0] start_i = '0;
    logic [31:0] result_o;
    logic        ack_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    prime_sieve_cop uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .stage_i  (stage_i),
        .start_i  (start_i),
        .result_o (result_o),
        .ack_o    (ack_o)
    );

    // Model: index is set after a build if some d in 2..SEEDS divides it with quotient >= 2.
    function automatic bit model_set(input int i);
        for (int d = 2; d <= SEEDS; d++) begin
            if (2 * d <= i && i % d == 0) return 1'b1;
        end
        return 1'b0;
    endfunction

    // Model: stopping index of a query (found index, or MAX_IDX when none); -1 when start is out of range.
    function automatic int model_stop(input int s);
        if (s > MAX_IDX) return -1;
        for (int f = s; f <= MAX_IDX; f++) begin
            if (!model_set(f)) return f;
        end
        return MAX_IDX;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Issue one request; returns the result seen during ack and the ack cycle count.
    task automatic do_req(input logic [31:0] stg, input logic [31:0] st,
                          output logic [31:0] res, output int lat);
        @(negedge clk);
        stage_i = stg;
        start_i = st;
        req_i   = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        lat   = 1;
        while (!ack_o) begin
            @(negedge clk);
            lat++;
        end
        res = result_o;
        @(negedge clk);
        check(!ack_o, "R2 ack single cycle", int'(ack_o), 0);
    endtask

    // Query from s and compare answer and latency with the model.
    task automatic query_check(input int s);
        logic [31:0] res;
        int lat;
        int stop;
        int exp_res;
        int exp_lat;
        stop = model_stop(s);
        if (stop < 0) begin
            exp_res = 0;
            exp_lat = 1;
        end else begin
            exp_res = (stop == MAX_IDX && model_set(MAX_IDX)) ? 0 : stop;
            exp_lat = 2 * (stop - s) + 3;
        end
        do_req(32'd1, 32'(s), res, lat);
        if (s <= 1)
            check(res == 32'(exp_res), "R9 low index answer", int'(res), exp_res);
        else if (exp_res == 0)
            check(res == 32'(exp_res), "R6 empty query", int'(res), exp_res);
        else
            check(res == 32'(exp_res), "R5 query answer", int'(res), exp_res);
        check(lat == exp_lat, "R8 query latency", lat, exp_lat);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] res;
        int lat;

        // R1: reset state.
        repeat (3) @(negedge clk);
        check(ack_o == 1'b0, "R1 ack low in reset", int'(ack_o), 0);
        check(result_o == 32'd0, "R1 result zero in reset", int'(result_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ack_o == 1'b0, "R1 idle after reset", int'(ack_o), 0);

        // R4: build; result held at its reset value.
        do_req(32'd0, 32'd0, res, lat);
        check(res == 32'd0, "R4 build keeps result", int'(res), 0);

        // R5 R6 R8 R9: every start index from 0 past the top.
        for (int s = 0; s <= MAX_IDX + 6; s++) begin
            query_check(s);
        end
        query_check(32'h7FFF_FFFF);

        // R3: no-op modes leave result and flags untouched.
        do_req(32'd1, 32'd100, res, lat);
        check(res == 32'd101, "R5 query from 100", int'(res), 101);
        do_req(32'd2, 32'd5, res, lat);
        check(lat == 1, "R3 no-op latency", lat, 1);
        check(res == 32'd101, "R3 no-op keeps result", int'(res), 101);
        do_req(32'hFFFF_FFFF, 32'd0, res, lat);
        check(lat == 1, "R3 no-op latency all ones", lat, 1);
        check(res == 32'd101, "R3 no-op keeps result all ones", int'(res), 101);
        for (int s = 0; s <= MAX_IDX; s += 37) begin
            query_check(s);
        end

        // R4: a second build leaves the held answer alone and rebuilds the same flags.
        do_req(32'd1, 32'd900, res, lat);
        do_req(32'd0, 32'd0, res, lat);
        check(res == 32'd907, "R4 rebuild keeps result", int'(res), 907);

        // R1 R7: reset clears result but not the flags.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(result_o == 32'd0, "R1 result cleared by reset", int'(result_o), 0);
        check(ack_o == 1'b0, "R1 ack low after reset", int'(ack_o), 0);
        rst_n = 1'b1;
        for (int s = 0; s <= MAX_IDX + 2; s += 7) begin
            do_req(32'd1, 32'(s), res, lat);
            check(res == 32'((model_stop(s) < 0 || (model_stop(s) == MAX_IDX && model_set(MAX_IDX))) ? 0 : model_stop(s)),
                  "R7 flags survive reset", int'(res),
                  (model_stop(s) < 0 || (model_stop(s) == MAX_IDX && model_set(MAX_IDX))) ? 0 : model_stop(s));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule